// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This block is a register-mapped timer peripheral with a parameterised number of identical down-counting channels behind a simple single-cycle register bus. Each channel has a control register, an interval register and a read-only current-count register. The control register picks one of four tick sources and a power-of-two prescaler, and it chooses between periodic (auto-reload) and one-shot operation. All channels share one interrupt-enable register and one write-one-to-clear interrupt-status register. Together these two registers drive a single interrupt line.

The tick sources are single-cycle enable pulses that share the block clock. Software starts a channel by writing its control register with both the enable bit and the reload bit set. That write copies the interval into the counter. The count read back falls over time, so software inverts it to get a rising timestamp. Clearing the enable bit does not stop the counter at once. The channel keeps counting until a fixed number of ticks of its selected source have passed, and only then halts.

Top module: `mtimer_top`

## Requirements
- R1: After reset, every control, interval, count, interrupt-enable and interrupt-status register reads 0, every channel is stopped, and `irq` is 0.
- R2: A read presents its data on `rdata` at the clock edge where `rd_en` is sampled. The address map is as follows. Interrupt enable is at 0x00 (bit n is channel n). Interrupt status is at 0x04. For channel n, control is at 0x10*n+0x10, interval is at 0x10*n+0x14 and current count is at 0x10*n+0x18.
- R3: The control register has these fields: bit 0 enable, bit 1 reload, bits 3:2 source, bits 6:4 prescaler, bit 7 one-shot. A control write with bit 1 set copies the interval into the counter. Bit 1 always reads back as 0.
- R4: A channel counts only on pulses of the `src_tick` bit chosen by control bits 3:2. Pulses on the other bits leave its count unchanged.
- R5: With prescaler field p, the count falls by one every 2^p pulses of the selected source. The prescaler phase restarts on reload.
- R6: A running channel decrements once per prescaled tick. On a prescaled tick at count 0, it expires. In periodic mode (bit 7 = 0) it then reloads the interval and keeps running, so the period is interval+1 prescaled ticks.
- R7: In one-shot mode (bit 7 = 1), expiry stops the channel, clears control bit 0, and leaves the count at 0.
- R8: Expiry of channel n sets status bit n. Writing 1 to a status bit clears it, and writing 0 has no effect. A set and a clear in the same cycle leave the bit set.
- R9: `irq` is the OR of the status bits masked by the enable bits. It follows the registers in the same cycle.
- R10: After a control write clears bit 0 on a running channel, the bit reads 0 at once. The counter keeps counting through the next STOP_TICKS (default 2) pulses of its source, counting the last one, and then holds.
- R11: The interval is a full DATA_W bits. An all-ones interval loads an all-ones count that decrements from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 4 | Tick-enable pulses of the four count sources |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, registered |
| irq | output | 1 | Shared interrupt request |

## Verification
Each result is due in a fixed cycle after its stimulus:

- **Reads:** read data appears one edge after the read strobe.
- **Register writes:** a control or interval write takes effect at the edge that samples it.
- **Source ticks:** a one-cycle source pulse changes the count and the status bit at that same edge.
- **Interrupt line:** `irq` follows the status bit combinationally, with no added delay.

The bench drives every input at a falling edge and samples `irq` at the next falling edge. A driver task queues the expected read value when it issues the read strobe. A monitor pops that value and compares it at the falling edge that follows the capturing rising edge. Tick pulses are issued one at a time under bench control, so each expected count is an exact number.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

    localparam int NUM_SRC   = 4;
    localparam int CTRL_W    = 8;
    localparam int PRE_W     = 7;

    localparam int ADDR_IE   = 'h00;
    localparam int ADDR_ST   = 'h04;
    localparam int CH_BASE   = 'h10;
    localparam int CH_STRIDE = 'h10;
    localparam int OFF_CTRL  = 'h0;
    localparam int OFF_INTV  = 'h4;
    localparam int OFF_CNT   = 'h8;

    typedef struct packed {
        logic       oneshot;
        logic [2:0] pres;
        logic [1:0] src;
        logic       reload;
        logic       en;
    } ctrl_t;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_RUN   = 2'd1,
        CH_DRAIN = 2'd2
    } chst_e;

    function automatic int ch_addr(input int ch, input int off);
        return CH_BASE + CH_STRIDE * ch + off;
    endfunction

    function automatic logic [PRE_W-1:0] pre_mask(input logic [2:0] p);
        return (PRE_W'(1) << p) - PRE_W'(1);
    endfunction

endpackage

// File: rtl/mtimer_chan.sv
module mtimer_chan
    import mtimer_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int STOP_TICKS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   src_tick,
    input  logic                 ctrl_wr,
    input  logic                 intv_wr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [CTRL_W-1:0]    ctrl_q,
    output logic [DATA_W-1:0]    intv_q,
    output logic [DATA_W-1:0]    count_q,
    output logic                 expire
);
    localparam int SC_W = $clog2(STOP_TICKS + 1);

    ctrl_t              ctrl_r;
    ctrl_t              ctrl_new;
    chst_e              state;
    logic [SC_W-1:0]    stop_cnt;
    logic [PRE_W-1:0]   pc;
    logic [DATA_W-1:0]  intv_r;
    logic [DATA_W-1:0]  count_r;
    logic               tick;
    logic               running;
    logic               pre_last;
    logic               pre_tick;

    assign ctrl_new = ctrl_t'(wdata[CTRL_W-1:0]);
    assign tick     = src_tick[ctrl_r.src];
    assign running  = (state != CH_IDLE);
    assign pre_last = (pc == pre_mask(ctrl_r.pres));
    assign pre_tick = running && tick && pre_last;
    assign expire   = pre_tick && (count_r == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_r   <= '0;
            state    <= CH_IDLE;
            stop_cnt <= '0;
            pc       <= '0;
            intv_r   <= '0;
            count_r  <= '0;
        end else begin
            if (running && tick)
                pc <= pre_last ? '0 : pc + PRE_W'(1);

            if (pre_tick) begin
                if (count_r == '0) begin
                    if (ctrl_r.oneshot) begin
                        state     <= CH_IDLE;
                        ctrl_r.en <= 1'b0;
                    end else begin
                        count_r <= intv_r;
                    end
                end else begin
                    count_r <= count_r - DATA_W'(1);
                end
            end

            if (state == CH_DRAIN && tick) begin
                if (stop_cnt == SC_W'(STOP_TICKS - 1)) begin
                    state    <= CH_IDLE;
                    stop_cnt <= '0;
                end else begin
                    stop_cnt <= stop_cnt + SC_W'(1);
                end
            end

            if (intv_wr)
                intv_r <= wdata;

            if (ctrl_wr) begin
                ctrl_r        <= ctrl_new;
                ctrl_r.reload <= 1'b0;
                if (ctrl_new.reload) begin
                    count_r <= intv_r;
                    pc      <= '0;
                end
                if (ctrl_new.en) begin
                    state    <= CH_RUN;
                    stop_cnt <= '0;
                end else if (state == CH_RUN) begin
                    state    <= CH_DRAIN;
                    stop_cnt <= '0;
                end
            end
        end
    end

    assign ctrl_q  = ctrl_r;
    assign intv_q  = intv_r;
    assign count_q = count_r;

endmodule

// File: rtl/mtimer_irq.sv
module mtimer_irq #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ie_wr,
    input  logic              st_wr,
    input  logic [NUM_CH-1:0] wbits,
    input  logic [NUM_CH-1:0] expire,
    output logic [NUM_CH-1:0] ie_q,
    output logic [NUM_CH-1:0] status_q,
    output logic              irq
);
    logic [NUM_CH-1:0] clr_mask;

    assign clr_mask = st_wr ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q     <= '0;
            status_q <= '0;
        end else begin
            if (ie_wr)
                ie_q <= wbits;
            status_q <= (status_q & ~clr_mask) | expire;
        end
    end

    assign irq = |(status_q & ie_q);

endmodule

// File: rtl/mtimer_regif.sv
module mtimer_regif
    import mtimer_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [NUM_CH-1:0]             ie_q,
    input  logic [NUM_CH-1:0]             status_q,
    input  logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_all,
    input  logic [NUM_CH-1:0][DATA_W-1:0] intv_all,
    input  logic [NUM_CH-1:0][DATA_W-1:0] count_all,
    output logic                          ie_wr,
    output logic                          st_wr,
    output logic [NUM_CH-1:0]             ctrl_wr,
    output logic [NUM_CH-1:0]             intv_wr,
    output logic [DATA_W-1:0]             rdata
);
    logic [DATA_W-1:0] rd_mux;

    assign ie_wr = wr_en && (addr == ADDR_W'(ADDR_IE));
    assign st_wr = wr_en && (addr == ADDR_W'(ADDR_ST));

    genvar n;
    generate
        for (n = 0; n < NUM_CH; n++) begin : g_dec
            assign ctrl_wr[n] = wr_en && (addr == ADDR_W'(ch_addr(n, OFF_CTRL)));
            assign intv_wr[n] = wr_en && (addr == ADDR_W'(ch_addr(n, OFF_INTV)));
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        if (addr == ADDR_W'(ADDR_IE))
            rd_mux = DATA_W'(ie_q);
        if (addr == ADDR_W'(ADDR_ST))
            rd_mux = DATA_W'(status_q);
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr == ADDR_W'(ch_addr(c, OFF_CTRL)))
                rd_mux = DATA_W'(ctrl_all[c]);
            if (addr == ADDR_W'(ch_addr(c, OFF_INTV)))
                rd_mux = intv_all[c];
            if (addr == ADDR_W'(ch_addr(c, OFF_CNT)))
                rd_mux = count_all[c];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_mux;
    end

endmodule

// File: rtl/mtimer_top.sv
module mtimer_top
    import mtimer_pkg::*;
#(
    parameter int NUM_CH     = 2,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 8,
    parameter int STOP_TICKS = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [3:0]         src_tick,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq
);
    logic                          ie_wr;
    logic                          st_wr;
    logic [NUM_CH-1:0]             ctrl_wr;
    logic [NUM_CH-1:0]             intv_wr;
    logic [NUM_CH-1:0]             ie_q;
    logic [NUM_CH-1:0]             status_q;
    logic [NUM_CH-1:0]             expire;
    logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_all;
    logic [NUM_CH-1:0][DATA_W-1:0] intv_all;
    logic [NUM_CH-1:0][DATA_W-1:0] count_all;

    mtimer_regif #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) regif_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .ie_q      (ie_q),
        .status_q  (status_q),
        .ctrl_all  (ctrl_all),
        .intv_all  (intv_all),
        .count_all (count_all),
        .ie_wr     (ie_wr),
        .st_wr     (st_wr),
        .ctrl_wr   (ctrl_wr),
        .intv_wr   (intv_wr),
        .rdata     (rdata)
    );

    genvar n;
    generate
        for (n = 0; n < NUM_CH; n++) begin : g_ch
            mtimer_chan #(
                .DATA_W     (DATA_W),
                .STOP_TICKS (STOP_TICKS)
            ) chan_i (
                .clk      (clk),
                .rst      (rst),
                .src_tick (src_tick),
                .ctrl_wr  (ctrl_wr[n]),
                .intv_wr  (intv_wr[n]),
                .wdata    (wdata),
                .ctrl_q   (ctrl_all[n]),
                .intv_q   (intv_all[n]),
                .count_q  (count_all[n]),
                .expire   (expire[n])
            );
        end
    endgenerate

    mtimer_irq #(
        .NUM_CH (NUM_CH)
    ) irq_i (
        .clk      (clk),
        .rst      (rst),
        .ie_wr    (ie_wr),
        .st_wr    (st_wr),
        .wbits    (wdata[NUM_CH-1:0]),
        .expire   (expire),
        .ie_q     (ie_q),
        .status_q (status_q),
        .irq      (irq)
    );

endmodule

// File: rtl/mtimer_chk.sv
module mtimer_chk
    import mtimer_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 32
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          irq,
    input logic                          st_wr,
    input logic [DATA_W-1:0]             wdata,
    input logic [NUM_CH-1:0]             status_q,
    input logic [NUM_CH-1:0]             expire,
    input logic [NUM_CH-1:0]             ctrl_wr,
    input logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_all,
    input logic [NUM_CH-1:0][DATA_W-1:0] intv_all,
    input logic [NUM_CH-1:0][DATA_W-1:0] count_all
);
    // R1
    irq_quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq);

    genvar n;
    generate
        for (n = 0; n < NUM_CH; n++) begin : g_chk
            // R8
            status_from_expiry_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(status_q[n]) |-> $past(expire[n]));

            // R8
            set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
                (st_wr && wdata[n] && expire[n]) |=> status_q[n]);

            // R3
            reload_copies_chk: assert property (@(posedge clk) disable iff (rst)
                (ctrl_wr[n] && wdata[1]) |=> (count_all[n] == $past(intv_all[n])));

            // R6
            periodic_reload_chk: assert property (@(posedge clk) disable iff (rst)
                (expire[n] && !ctrl_all[n][7] && !ctrl_wr[n])
                    |=> (count_all[n] == $past(intv_all[n])));

            // R7
            oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
                (expire[n] && ctrl_all[n][7] && !ctrl_wr[n])
                    |=> (!ctrl_all[n][0] && count_all[n] == '0));
        end
    endgenerate

endmodule

bind mtimer_top mtimer_chk #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .irq       (irq),
    .st_wr     (st_wr),
    .wdata     (wdata),
    .status_q  (status_q),
    .expire    (expire),
    .ctrl_wr   (ctrl_wr),
    .ctrl_all  (ctrl_all),
    .intv_all  (intv_all),
    .count_all (count_all)
);

// File: tb/mtimer_tb.sv
`timescale 1ns/1ps
module mtimer_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  src_tick = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks_n = 0;
    int fail_n   = 0;
    bit done     = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_q = 1'b0;

    always #2.5 clk = ~clk;

    mtimer_top dut_i (
        .clk      (clk),
        .rst      (rst),
        .src_tick (src_tick),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .irq      (irq)
    );

    always @(posedge clk) rd_q <= rd_en;

    // Monitor: read data was captured at the rising edge after rd_en
    always @(negedge clk) begin
        if (rd_q && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks_n++;
            if (rdata !== e) begin
                fail_n++;
                $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            src_tick = m;
            @(negedge clk);
            src_tick = '0;
        end
    endtask

    task automatic check_irq(input logic e, input string t);
        @(negedge clk);
        checks_n++;
        if (irq !== e) begin
            fail_n++;
            $display("FAIL %s: irq=%b expected=%b", t, irq, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks_n, fail_n);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks_n++;
        fail_n++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 / R2: reset values across the map
        bus_read(8'h00, 32'h0, "R1 ie");
        bus_read(8'h04, 32'h0, "R1 status");
        bus_read(8'h10, 32'h0, "R1 ctrl0");
        bus_read(8'h14, 32'h0, "R1 intv0");
        bus_read(8'h18, 32'h0, "R1 count0");
        bus_read(8'h28, 32'h0, "R1 count1");
        check_irq(1'b0, "R1 irq");

        // R3: enable+reload on ch0, source 1, prescaler 0
        bus_write(8'h14, 32'd5);
        bus_write(8'h10, 32'h07);
        bus_read(8'h10, 32'h05, "R3 reload bit reads 0");
        bus_read(8'h14, 32'd5, "R2 interval readback");
        bus_read(8'h18, 32'd5, "R3 interval copied");

        // R6: decrement per tick; R4: other sources ignored
        pulse(4'b0010, 3);
        bus_read(8'h18, 32'd2, "R6 decrement");
        pulse(4'b0001, 2);
        pulse(4'b1000, 1);
        bus_read(8'h18, 32'd2, "R4 unselected sources");

        // R5: ch1, source 2, prescaler 2 (divide by 4)
        bus_write(8'h24, 32'd100);
        bus_write(8'h20, 32'h2B);
        pulse(4'b0100, 7);
        bus_read(8'h28, 32'd99, "R5 prescale 7 pulses");
        pulse(4'b0100, 1);
        bus_read(8'h28, 32'd98, "R5 prescale 8 pulses");

        // R6 / R8 / R9: periodic expiry on ch0
        pulse(4'b0010, 2);
        bus_read(8'h18, 32'd0, "R6 at zero");
        bus_read(8'h04, 32'h0, "R8 no status before expiry");
        pulse(4'b0010, 1);
        bus_read(8'h18, 32'd5, "R6 periodic reload");
        bus_read(8'h04, 32'h1, "R8 status set");
        check_irq(1'b0, "R9 masked");
        bus_write(8'h00, 32'h1);
        check_irq(1'b1, "R9 enabled");
        bus_write(8'h04, 32'h0);
        bus_read(8'h04, 32'h1, "R8 write 0 no effect");
        bus_write(8'h04, 32'h1);
        bus_read(8'h04, 32'h0, "R8 write 1 clears");
        check_irq(1'b0, "R9 cleared");

        // R7: one-shot on ch0
        bus_write(8'h14, 32'd1);
        bus_write(8'h10, 32'h87);
        bus_read(8'h18, 32'd1, "R7 loaded");
        pulse(4'b0010, 2);
        bus_read(8'h04, 32'h1, "R7 expiry status");
        bus_read(8'h10, 32'h84, "R7 enable cleared");
        bus_write(8'h04, 32'h1);
        pulse(4'b0010, 3);
        bus_read(8'h18, 32'd0, "R7 holds at 0");
        bus_read(8'h04, 32'h0, "R7 no further expiry");

        // R10: delayed stop on ch1
        bus_write(8'h24, 32'd10);
        bus_write(8'h20, 32'h0B);
        bus_write(8'h20, 32'h08);
        bus_read(8'h20, 32'h08, "R10 enable reads 0");
        pulse(4'b0100, 1);
        bus_read(8'h28, 32'd9, "R10 first drain tick");
        pulse(4'b0100, 1);
        bus_read(8'h28, 32'd8, "R10 second drain tick");
        pulse(4'b0100, 3);
        bus_read(8'h28, 32'd8, "R10 halted");

        // R11: all-ones interval on ch1, source 3
        bus_write(8'h24, 32'hFFFF_FFFF);
        bus_write(8'h20, 32'h0F);
        bus_read(8'h24, 32'hFFFF_FFFF, "R11 interval full width");
        bus_read(8'h28, 32'hFFFF_FFFF, "R11 loaded");
        pulse(4'b1000, 1);
        bus_read(8'h28, 32'hFFFF_FFFE, "R11 decrement");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule